// File: doc/BRIEF.md
# Iterative RC5 Block Encryption Core

This block encrypts one 2w-bit data block at a time with the RC5 round function, where the word size w and the round count r are parameters. Before any encryption, the surrounding logic loads the 2r+2 round keys through an indexed write port. The keys are split across two memories by index parity: even-indexed keys go to one bank and odd-indexed keys go to the other. Because of this split, each round can fetch its key pair with a single read from each bank.

Writing a block starts the encryption with no further command. One cycle is spent on the key whitening step, and every cycle after that completes one full round, including both data-dependent rotations. The block therefore finishes r+1 cycles after it is captured. The ciphertext appears on a registered output together with a one-cycle done pulse, and it stays there until the next encryption finishes.

Top module: `rc5_iter_core`

## Requirements
- R1: Writing a key requires `key_wr` high at a rising edge. Key index i is stored in the even bank when i[0]=0 and in the odd bank when i[0]=1, at address i>>1. An index of 2r+2 or above leaves both banks unchanged.
- R2: A `blk_wr` sampled high while the core is idle captures `blk_in` and starts an encryption. The upper w bits (2w-1..w) become word A and the lower w bits become word B.
- R3: The first processing cycle adds key 0 to A and key 1 to B, each modulo 2^w.
- R4: Round j (1..r) computes A' = rotl(A xor B, B mod w) + key 2j. It then computes B' = rotl(B xor A', A' mod w) + key 2j+1. The rotation amount is the low log2(w) bits of the rotating operand.
- R5: `done` goes high exactly r+1 rising edges after the edge that captured the block. It stays low on all of the edges in between.
- R6: `done` is high for exactly one cycle per encryption.
- R7: `ct_out` equals {A,B} after the last round, with A in the upper half. It changes only on the edge where `done` rises and otherwise holds its value.
- R8: After reset, `done` is low. `ct_out` reads zero until the first encryption completes.
- R9: A `blk_wr` that arrives while an encryption is in progress is ignored. It does not restart the run, change the result, or produce an extra `done`.
- R10: A key rewritten between two encryptions takes effect in the next encryption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| key_wr | input | 1 | Round-key write strobe |
| key_idx | input | $clog2(2*ROUNDS+2) | Round-key index |
| key_val | input | WORD_W | Round-key value |
| blk_wr | input | 1 | Block write strobe; starts encryption when idle |
| blk_in | input | 2*WORD_W | Plaintext block, word A in the upper half |
| ct_out | output | 2*WORD_W | Registered ciphertext |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `blk_wr` arriving during a run is legal and must be dropped. They also assume that keys are never rewritten while a run is using them, because the memories hold no copy of the old value. The stimulus therefore changes keys only while the core is idle. It injects extra block writes only in the middle of a run, and it waits one idle cycle after each `done` before starting the next block. The checks for out-of-range key indices use the small configuration (w=8, r=4), where indices 10 to 15 exist on the port but map to no storage.

// File: rtl/rc5_pkg.sv
package rc5_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_RUN  = 2'd2
  } rc5_state_e;

endpackage

// File: rtl/rc5_rotl.sv
module rc5_rotl #(
  parameter int WORD_W = 16,
  localparam int SH_W  = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] val_i,
  input  logic [SH_W-1:0]   amt_i,
  output logic [WORD_W-1:0] rot_o
);

  // Rotating a doubled word by amt and keeping the top half gives rotl.
  logic [2*WORD_W-1:0] dbl;

  always_comb begin
    dbl   = {val_i, val_i} << amt_i;
    rot_o = dbl[2*WORD_W-1:WORD_W];
  end

endmodule

// File: rtl/rc5_round.sv
module rc5_round #(
  parameter int WORD_W = 16,
  localparam int SH_W  = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [WORD_W-1:0] ka_i,
  input  logic [WORD_W-1:0] kb_i,
  output logic [WORD_W-1:0] a_o,
  output logic [WORD_W-1:0] b_o
);

  logic [WORD_W-1:0] a_mix, a_rot, b_mix, b_rot;

  assign a_mix = a_i ^ b_i;

  rc5_rotl #(.WORD_W(WORD_W)) u_rot_a (
    .val_i (a_mix),
    .amt_i (b_i[SH_W-1:0]),
    .rot_o (a_rot)
  );

  assign a_o   = a_rot + ka_i;
  assign b_mix = b_i ^ a_o;

  rc5_rotl #(.WORD_W(WORD_W)) u_rot_b (
    .val_i (b_mix),
    .amt_i (a_o[SH_W-1:0]),
    .rot_o (b_rot)
  );

  assign b_o = b_rot + kb_i;

endmodule

// File: rtl/rc5_key_bank.sv
module rc5_key_bank #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 13,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);

  // Simple dual-port layout: one write port, one registered read port.
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    rd_data_o <= mem[rd_addr_i];
  end

endmodule

// File: rtl/rc5_ctrl.sv
module rc5_ctrl #(
  parameter int ROUNDS = 12,
  localparam int CW    = $clog2(ROUNDS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req_i,
  output logic          busy_o,
  output logic          load_o,
  output logic          init_o,
  output logic          step_o,
  output logic          finish_o,
  output logic [CW-1:0] rd_addr_o
);
  import rc5_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(ROUNDS);

  rc5_state_e    state_q;
  logic [CW-1:0] cnt_q;

  assign busy_o   = (state_q != ST_IDLE);
  assign load_o   = (state_q == ST_IDLE) && start_req_i;
  assign init_o   = (state_q == ST_INIT);
  assign step_o   = (state_q == ST_RUN);
  assign finish_o = (state_q == ST_RUN) && (cnt_q == LAST);

  // Fetch one entry ahead: the registered read lands when it is consumed.
  always_comb begin
    if (state_q == ST_IDLE || cnt_q == LAST) rd_addr_o = '0;
    else                                     rd_addr_o = cnt_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_req_i) begin
          state_q <= ST_INIT;
          cnt_q   <= '0;
        end
        ST_INIT: begin
          state_q <= ST_RUN;
          cnt_q   <= CW'(1);
        end
        ST_RUN: begin
          if (cnt_q == LAST) state_q <= ST_IDLE;
          else               cnt_q   <= cnt_q + CW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: the round index never leaves 1..r while rounds execute
  assert_round_range_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |-> (cnt_q >= CW'(1) && cnt_q <= LAST));

  // R9: a block write during a run never causes a restart
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_req_i) |=> (state_q != ST_INIT));

endmodule

// File: rtl/rc5_iter_core.sv
module rc5_iter_core #(
  parameter int WORD_W  = 16,
  parameter int ROUNDS  = 12,
  localparam int NKEYS  = 2 * ROUNDS + 2,
  localparam int IDX_W  = $clog2(NKEYS),
  localparam int DEPTH  = ROUNDS + 1,
  localparam int AW     = $clog2(DEPTH),
  localparam int BLK_W  = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [IDX_W-1:0]  key_idx,
  input  logic [WORD_W-1:0] key_val,
  input  logic              blk_wr,
  input  logic [BLK_W-1:0]  blk_in,
  output logic [BLK_W-1:0]  ct_out,
  output logic              done
);

  localparam logic [IDX_W:0] KEY_LIMIT = (IDX_W + 1)'(NKEYS);

  logic          busy, load, init, step, finish;
  logic [AW-1:0] rd_addr;
  logic          idx_ok;
  logic [WORD_W-1:0] key_rd [2];
  logic [WORD_W-1:0] a_q, b_q, a_nx, b_nx;
  logic [AW:0]   lat_q;

  rc5_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_req_i (blk_wr),
    .busy_o      (busy),
    .load_o      (load),
    .init_o      (init),
    .step_o      (step),
    .finish_o    (finish),
    .rd_addr_o   (rd_addr)
  );

  assign idx_ok = ({1'b0, key_idx} < KEY_LIMIT);

  // Bank 0 holds even-indexed keys, bank 1 odd-indexed keys.
  for (genvar p = 0; p < 2; p++) begin : g_bank
    logic wr_hit;
    assign wr_hit = key_wr && idx_ok && (key_idx[0] == p[0]);

    rc5_key_bank #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_bank (
      .clk       (clk),
      .wr_en_i   (wr_hit),
      .wr_addr_i (key_idx[IDX_W-1:1]),
      .wr_data_i (key_val),
      .rd_addr_i (rd_addr),
      .rd_data_o (key_rd[p])
    );
  end

  rc5_round #(.WORD_W(WORD_W)) u_round (
    .a_i  (a_q),
    .b_i  (b_q),
    .ka_i (key_rd[0]),
    .kb_i (key_rd[1]),
    .a_o  (a_nx),
    .b_o  (b_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load) begin
      a_q <= blk_in[BLK_W-1:WORD_W];
      b_q <= blk_in[WORD_W-1:0];
    end else if (init) begin
      a_q <= a_q + key_rd[0];
      b_q <= b_q + key_rd[1];
    end else if (step) begin
      a_q <= a_nx;
      b_q <= b_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ct_out <= '0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      if (finish) ct_out <= {a_nx, b_nx};
    end
  end

  // Cycle count since capture, kept only for the latency check.
  always_ff @(posedge clk) begin
    if (rst || load)  lat_q <= '0;
    else if (busy)    lat_q <= lat_q + (AW + 1)'(1);
  end

  // R5: done arrives r+1 edges after the capture edge
  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_q == (AW + 1)'(ROUNDS + 1)));

  // R6: done lasts a single cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: the ciphertext moves only together with done
  assert_ct_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(ct_out) |-> done);

  // R8: reset clears the output and the pulse
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (ct_out == '0 && !done));

  // R2: done is only produced by an encryption that was running
  assert_done_after_run_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

endmodule

// File: tb/rc5_iter_core_tb.sv
module rc5_iter_core_tb;

  localparam int W  = 8;
  localparam int R  = 4;
  localparam int NK = 2 * R + 2;
  localparam int IW = $clog2(NK);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          key_wr = 1'b0;
  logic [IW-1:0] key_idx = '0;
  logic [W-1:0]  key_val = '0;
  logic          blk_wr = 1'b0;
  logic [2*W-1:0] blk_in = '0;
  logic [2*W-1:0] ct_out;
  logic          done;

  int n_checks = 0;
  int n_errs   = 0;
  logic [W-1:0] keys [NK];

  always #10 clk = ~clk;

  rc5_iter_core #(.WORD_W(W), .ROUNDS(R)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .key_wr  (key_wr),
    .key_idx (key_idx),
    .key_val (key_val),
    .blk_wr  (blk_wr),
    .blk_in  (blk_in),
    .ct_out  (ct_out),
    .done    (done)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int n);
    logic [2*W-1:0] t;
    t = {8'h00, x} << n;
    return t[W-1:0] | t[2*W-1:W];
  endfunction

  function automatic logic [2*W-1:0] model(input logic [2*W-1:0] m);
    logic [W-1:0] a, b;
    a = m[2*W-1:W] + keys[0];
    b = m[W-1:0] + keys[1];
    for (int j = 1; j <= R; j++) begin
      a = rotl(a ^ b, int'(b[2:0])) + keys[2*j];
      b = rotl(b ^ a, int'(a[2:0])) + keys[2*j+1];
    end
    return {a, b};
  endfunction

  task automatic put_key(input int idx, input logic [W-1:0] v);
    @(negedge clk);
    key_wr  = 1'b1;
    key_idx = IW'(idx);
    key_val = v;
    @(negedge clk);
    key_wr  = 1'b0;
  endtask

  // Runs one block; inject=1 drives a second block write mid-run.
  task automatic run_block(input logic [2*W-1:0] m, input bit inject,
                           input string req);
    logic [2*W-1:0] exp, prev;
    bit early_done, moved;
    exp = model(m);
    @(negedge clk);
    blk_wr = 1'b1;
    blk_in = m;
    @(negedge clk);          // capture edge has passed
    blk_wr = 1'b0;
    blk_in = ~m;
    prev = ct_out;
    early_done = 1'b0;
    moved = 1'b0;
    for (int k = 1; k <= R + 1; k++) begin
      if (inject && k == 2) blk_wr = 1'b1;
      @(negedge clk);
      blk_wr = 1'b0;
      if (k <= R) begin
        if (done) early_done = 1'b1;
        if (ct_out !== prev) moved = 1'b1;
      end
    end
    check(!early_done && done === 1'b1, {"R5 latency ", req}, 32'(done), 32'd1);
    check(!moved, {"R7 hold ", req}, 32'(moved), 32'd0);
    check(ct_out === exp, {"R4 R7 value ", req}, 32'(ct_out), 32'(exp));
    @(negedge clk);
    check(done === 1'b0, {"R6 pulse ", req}, 32'(done), 32'd0);
    if (inject) begin
      bit extra;
      extra = 1'b0;
      for (int k = 0; k < R + 3; k++) begin
        @(negedge clk);
        if (done) extra = 1'b1;
      end
      check(!extra && ct_out === exp, {"R9 ignored ", req}, 32'(ct_out), 32'(exp));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check(ct_out === '0, "R8 ct_out after reset", 32'(ct_out), 32'd0);
    check(done === 1'b0, "R8 done after reset", 32'(done), 32'd0);

    // R1: load key set A
    for (int i = 0; i < NK; i++) begin
      keys[i] = W'(i * 29 + 7);
      put_key(i, keys[i]);
    end
    check(ct_out === '0, "R8 ct_out before first run", 32'(ct_out), 32'd0);

    // R1: indices beyond the key range must not touch either bank
    for (int i = NK; i < (1 << IW); i++) put_key(i, W'(8'hA5 ^ i));

    // R2 R3: whitening-only sensitive blocks, then a sweep
    run_block(16'h0000, 1'b0, "R3 zero block");
    run_block(16'hFFFF, 1'b0, "R3 ones block");
    run_block(16'hFF00, 1'b0, "R2 halves split");
    for (int i = 0; i < 400; i++)
      run_block(16'(i * 97 + 3), 1'b0, "R4 sweep keys A");

    // R9: block write during a run
    run_block(16'h1234, 1'b1, "R9 mid-run write");
    run_block(16'hBEEF, 1'b1, "R9 mid-run write 2");

    // R10: rewrite keys between runs
    for (int i = 0; i < NK; i++) begin
      keys[i] = ~W'(i * 53 + 1);
      put_key(i, keys[i]);
    end
    for (int i = 0; i < 400; i++)
      run_block(16'(i * 211 + 17), 1'b0, "R10 sweep keys B");

    // R10: single-key change, odd bank then even bank (R1 parity routing)
    keys[7] = 8'h3C;  put_key(7, keys[7]);
    run_block(16'h5A5A, 1'b0, "R10 R1 odd key change");
    keys[4] = 8'hC3;  put_key(4, keys[4]);
    run_block(16'h5A5A, 1'b0, "R10 R1 even key change");

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule